// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate coprocessor that a processor drives through a small window of word registers. One configuration register chooses the arithmetic operation, signed or unsigned operands, how many operand writes start a computation, a squaring option and a lock on the accumulator words. It also holds a sticky overflow flag and a self-clearing clear bit. Two operand registers feed the multiplier. The 48-bit accumulator is read and written as three 16-bit words.

Software does not issue a separate start command. Writing the last operand starts the computation, and the accumulator holds the new result one clock after that write. Operand writes may follow each other on consecutive cycles with no wait states. A signed product is sign-extended to the accumulator width, and an unsigned product is zero-extended.

Top module: `mac_unit`

Register addresses: 0 control, 1 operand A, 2 operand B, 3 accumulator bits 15:0, 4 bits 31:16, 5 bits 47:32. Control bits: 0 signed, 2:1 operation (00 multiply, 01 multiply-accumulate, 10 multiply-subtract, 11 multiply-negate), 3 single-operand, 4 square, 5 accumulator lock, 6 overflow (read only), 7 clear (write only).

## Requirements
- R1: After reset every register address 0 through 7 reads 0. Addresses 6 and 7 always read 0.
- R2: Operation 00 loads the accumulator with A*B. The product is zero-extended when control bit 0 is 0 and sign-extended when it is 1.
- R3: Operation 01 adds the extended product to the accumulator. Operation 10 subtracts it. Both wrap modulo 2^48.
- R4: Operation 11 loads the two's-complement negation of the signed product. With bit 0 clear it loads the plain unsigned product.
- R5: The accumulator changes exactly at the rising edge that follows the edge which stored the triggering operand. Before that edge it holds its old value.
- R6: Triggering writes on consecutive cycles each update the accumulator, one per cycle, with no lost operation.
- R7: With control bit 3 at 0, a computation starts only on a write to B that follows a write to A since the last computation. With bit 3 at 1, every write to B starts one, using the stored A.
- R8: With control bit 4 at 1, a write to A starts A*A, and a write to B starts nothing. B is still stored.
- R9: Control bit 6 sets when an accumulate or subtract overflows. For unsigned operations this is a carry or borrow out of bit 47. For signed operations it is two's-complement overflow. The bit stays set through later operations, and writes to bit 6 are ignored.
- R10: Writing control with bit 7 at 1 zeroes both operands, the accumulator, the overflow flag and the arming state. Bits 5:0 take the written value, and bit 7 always reads 0.
- R11: Writes to addresses 3, 4 and 5 replace the low, middle and high accumulator words. They are ignored while control bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |

## Verification
The core sweep crosses eight operand values with each other: zero, one, two, both signed extremes, the value just above the most negative one, all-ones and an ordinary mixed pattern. It runs under all four operations in both signedness modes. The sign-extremes separate sign extension from zero extension, and the chained accumulate and subtract runs expose both wraparound and missing or spurious overflow. Directed sequences sample the accumulator one cycle early and then on time, issue consecutive triggering writes, and write B without arming. They also run squaring, clear, and lock against direct word writes.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      OP_MUL  = 2'd0,
      OP_MAC  = 2'd1,
      OP_MSUB = 2'd2,
      OP_NEG  = 2'd3
   } mac_op_e;

   // Stored control fields, MSB first: lock, square, single, op, signed
   typedef struct packed {
      logic    lock;
      logic    square;
      logic    single;
      mac_op_e op;
      logic    sgn;
   } mac_cfg_t;

   localparam int CFG_W    = $bits(mac_cfg_t);
   localparam int BIT_OVF  = 6;
   localparam int BIT_CLR  = 7;
   localparam int CTRL_W   = 8;

   localparam int ADR_CTRL = 0;
   localparam int ADR_OPA  = 1;
   localparam int ADR_OPB  = 2;
   localparam int ADR_ACC0 = 3;

endpackage

// File: rtl/mac_trigger.sv
module mac_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr_a,
   input  logic wr_b,
   input  logic single,
   input  logic square,
   output logic fire
);

   logic armed_q;

   // R7/R8: start rules
   always_comb begin
      if (square) fire = wr_a;
      else        fire = wr_b && (single || armed_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            armed_q <= 1'b0;
      else if (clr || fire)  armed_q <= 1'b0;
      else if (wr_a)         armed_q <= 1'b1;
   end

endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
   parameter int OP_W   = 16,
   parameter bit SHARED = 1'b1,
   localparam int PROD_W = 2 * OP_W
) (
   input  logic [OP_W-1:0]   a,
   input  logic [OP_W-1:0]   b,
   input  logic              sgn,
   output logic [PROD_W-1:0] prod
);

   generate
      if (SHARED) begin : g_shared
         // One (OP_W+1)-bit signed array serves both operand types
         logic signed [OP_W:0]     xa, xb;
         logic signed [PROD_W+1:0] full;
         always_comb begin
            xa   = {sgn & a[OP_W-1], a};
            xb   = {sgn & b[OP_W-1], b};
            full = xa * xb;
            prod = full[PROD_W-1:0];
         end
      end else begin : g_split
         // Two arrays, result picked after the fact
         logic        [PROD_W-1:0] pu;
         logic signed [PROD_W-1:0] ps;
         always_comb begin
            pu   = {{OP_W{1'b0}}, a} * {{OP_W{1'b0}}, b};
            ps   = $signed({{OP_W{a[OP_W-1]}}, a}) * $signed({{OP_W{b[OP_W-1]}}, b});
            prod = sgn ? ps : pu;
         end
      end
   endgenerate

endmodule

// File: rtl/mac_accum.sv
module mac_accum
   import mac_pkg::*;
#(
   parameter int ACC_W  = 48,
   parameter int PROD_W = 32
) (
   input  logic [ACC_W-1:0]  acc_cur,
   input  logic [PROD_W-1:0] prod,
   input  logic              sgn,
   input  mac_op_e           op,
   output logic [ACC_W-1:0]  acc_nxt,
   output logic              ovf_evt
);

   localparam int EXT_W = ACC_W - PROD_W;
   localparam int MSB   = ACC_W - 1;

   logic [ACC_W-1:0] ext, neg;
   logic [ACC_W:0]   sum, diff;

   always_comb begin
      ext  = sgn ? {{EXT_W{prod[PROD_W-1]}}, prod} : {{EXT_W{1'b0}}, prod};
      neg  = '0 - ext;
      sum  = {1'b0, acc_cur} + {1'b0, ext};
      diff = {1'b0, acc_cur} - {1'b0, ext};
      unique case (op)
         OP_MUL: begin
            acc_nxt = ext;
            ovf_evt = 1'b0;
         end
         OP_MAC: begin
            acc_nxt = sum[MSB:0];
            ovf_evt = sgn ? ((acc_cur[MSB] == ext[MSB]) && (sum[MSB] != acc_cur[MSB]))
                          : sum[ACC_W];
         end
         OP_MSUB: begin
            acc_nxt = diff[MSB:0];
            ovf_evt = sgn ? ((acc_cur[MSB] != ext[MSB]) && (diff[MSB] != acc_cur[MSB]))
                          : diff[ACC_W];
         end
         default: begin
            acc_nxt = sgn ? neg : ext;
            ovf_evt = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int OP_W        = 16,
   parameter int ACC_W       = 48,
   parameter int ADDR_W      = 3,
   parameter bit SHARED_MULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [OP_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [OP_W-1:0]   rd_data
);

   localparam int PROD_W    = 2 * OP_W;
   localparam int ACC_WORDS = ACC_W / OP_W;
   localparam int PAD_W     = OP_W - CTRL_W;

   generate
      if (ACC_W <= PROD_W) begin : g_chk_acc
         $error("mac_unit: ACC_W must exceed twice OP_W");
      end
      if (ACC_W % OP_W != 0) begin : g_chk_words
         $error("mac_unit: ACC_W must be a multiple of OP_W");
      end
      if (OP_W < CTRL_W) begin : g_chk_opw
         $error("mac_unit: OP_W must hold the control byte");
      end
      if (ADR_ACC0 + ACC_WORDS > (1 << ADDR_W)) begin : g_chk_addr
         $error("mac_unit: address space too small for accumulator words");
      end
   endgenerate

   mac_cfg_t          cfg_q, go_cfg_q;
   logic [OP_W-1:0]   opa_q, opb_q, mul_b;
   logic [ACC_W-1:0]  acc_q, acc_wr_val, acc_nxt;
   logic [PROD_W-1:0] prod;
   logic              ovf_q, ovf_evt, go_q, fire;
   logic              wr_ctrl, wr_a, wr_b, clr;
   logic [ACC_WORDS-1:0] acc_hit;
   logic              acc_addr_hit, acc_wr_en;

   // ---------------- register decode ----------------
   always_comb begin
      wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
      wr_a    = wr_en && (wr_addr == ADDR_W'(ADR_OPA));
      wr_b    = wr_en && (wr_addr == ADDR_W'(ADR_OPB));
      clr     = wr_ctrl && wr_data[BIT_CLR];
   end

   generate
      for (genvar w = 0; w < ACC_WORDS; w++) begin : g_word
         assign acc_hit[w] = wr_en && (wr_addr == ADDR_W'(ADR_ACC0 + w));
         assign acc_wr_val[w*OP_W +: OP_W] =
            (acc_hit[w] && !cfg_q.lock) ? wr_data : acc_q[w*OP_W +: OP_W];
      end
   endgenerate

   assign acc_addr_hit = |acc_hit;
   assign acc_wr_en    = acc_addr_hit && !cfg_q.lock;

   // ---------------- control and operands ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         opa_q <= '0;
         opb_q <= '0;
      end else begin
         if (wr_ctrl) cfg_q <= mac_cfg_t'(wr_data[CFG_W-1:0]);
         if (clr) begin
            opa_q <= '0;
            opb_q <= '0;
         end else begin
            if (wr_a) opa_q <= wr_data;
            if (wr_b) opb_q <= wr_data;
         end
      end
   end

   mac_trigger i_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .wr_a   (wr_a),
      .wr_b   (wr_b),
      .single (cfg_q.single),
      .square (cfg_q.square),
      .fire   (fire)
   );

   // Start pulse and the configuration it ran with
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q     <= 1'b0;
         go_cfg_q <= '0;
      end else begin
         go_q <= fire;
         if (fire) go_cfg_q <= cfg_q;
      end
   end

   // ---------------- datapath ----------------
   assign mul_b = go_cfg_q.square ? opa_q : opb_q;

   mac_multiplier #(
      .OP_W   (OP_W),
      .SHARED (SHARED_MULT)
   ) i_mult (
      .a    (opa_q),
      .b    (mul_b),
      .sgn  (go_cfg_q.sgn),
      .prod (prod)
   );

   mac_accum #(
      .ACC_W  (ACC_W),
      .PROD_W (PROD_W)
   ) i_acc (
      .acc_cur (acc_q),
      .prod    (prod),
      .sgn     (go_cfg_q.sgn),
      .op      (go_cfg_q.op),
      .acc_nxt (acc_nxt),
      .ovf_evt (ovf_evt)
   );

   // Priority: clear, then computation, then direct word writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (go_q) begin
         acc_q <= acc_nxt;
         ovf_q <= ovf_q | ovf_evt;
      end else if (acc_wr_en) begin
         acc_q <= acc_wr_val;
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADR_CTRL))
         rd_data = {{PAD_W{1'b0}}, 1'b0, ovf_q, cfg_q};
      else if (rd_addr == ADDR_W'(ADR_OPA))
         rd_data = opa_q;
      else if (rd_addr == ADDR_W'(ADR_OPB))
         rd_data = opb_q;
      for (int w = 0; w < ACC_WORDS; w++) begin
         if (rd_addr == ADDR_W'(ADR_ACC0 + w)) rd_data = acc_q[w*OP_W +: OP_W];
      end
   end

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
   parameter int ACC_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             acc_addr_hit,
   input logic             lock,
   input logic             square,
   input logic             wr_b,
   input logic             go,
   input logic [ACC_W-1:0] acc,
   input logic             ovf,
   input logic             rd_ctrl_sel,
   input logic             rd_clr_bit
);

   // R5: with nothing to load, the accumulator keeps its value
   a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && !clr && !acc_addr_hit) |=> $stable(acc));

   // R9: overflow is sticky until a clear
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

   // R10: clear empties accumulator and flag
   a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0 && !ovf));

   // R10: clear bit never reads back as one
   a_r10_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctrl_sel |-> !rd_clr_bit);

   // R8: in square mode a B write starts nothing
   a_r8_square_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && square) |=> !go);

   // R11: locked word writes leave the accumulator alone
   a_r11_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr_hit && lock && !go) |=> $stable(acc));

endmodule

bind mac_unit mac_unit_chk #(
   .ACC_W (ACC_W)
) i_mac_unit_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clr          (clr),
   .acc_addr_hit (acc_addr_hit),
   .lock         (cfg_q.lock),
   .square       (cfg_q.square),
   .wr_b         (wr_b),
   .go           (go_q),
   .acc          (acc_q),
   .ovf          (ovf_q),
   .rd_ctrl_sel  (rd_addr == ADDR_W'(mac_pkg::ADR_CTRL)),
   .rd_clr_bit   (rd_data[mac_pkg::BIT_CLR])
);

// File: tb/test_mac_unit.sv
module test_mac_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_unit i_mac_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   task automatic rd_acc(output logic [47:0] v);
      logic [15:0] w0, w1, w2;
      rd(3'd3, w0); rd(3'd4, w1); rd(3'd5, w2);
      v = {w2, w1, w0};
   endtask

   // Returns {overflow event, new accumulator}
   function automatic logic [48:0] model(input logic [47:0] acc, input logic [15:0] a,
                                         input logic [15:0] b, input logic sgn,
                                         input logic [1:0] op);
      logic [47:0] e;
      longint sa, sb, la, le, ls;
      logic [48:0] r;
      if (sgn) begin
         sa = longint'($signed(a)); sb = longint'($signed(b));
         ls = sa * sb;
         e  = ls[47:0];
      end else begin
         e = {32'b0, a} * {32'b0, b};
      end
      la = longint'($signed(acc));
      le = longint'($signed(e));
      case (op)
         2'd0: r = {1'b0, e};
         2'd1: begin
            if (sgn) begin
               ls = la + le;
               r = {(ls > 64'sh7FFF_FFFF_FFFF) || (ls < -64'sh8000_0000_0000), ls[47:0]};
            end else r = {1'b0, acc} + {1'b0, e};
         end
         2'd2: begin
            if (sgn) begin
               ls = la - le;
               r = {(ls > 64'sh7FFF_FFFF_FFFF) || (ls < -64'sh8000_0000_0000), ls[47:0]};
            end else r = {acc < e, acc - e};
         end
         default: r = sgn ? {1'b0, 48'd0 - e} : {1'b0, e};
      endcase
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [47:0] acc;
      logic [47:0] m_acc;
      logic        m_ovf;
      logic [48:0] r;
      logic [15:0] vals [8];
      string       tag;
      vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
               16'h8000, 16'h8001, 16'hFFFF, 16'h1234};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state of the whole register window
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 reset read", 64'(d), 64'd0);
      end

      // Sweep: every operation, both types, chained on the accumulator
      for (int s = 0; s < 2; s++) begin
         for (int op = 0; op < 4; op++) begin
            wr(3'd0, 16'h0080 | 16'(op << 1) | 16'(s));
            m_acc = '0; m_ovf = 1'b0;
            tag = (op == 0) ? "R2" : (op == 3) ? "R4" : "R3";
            for (int i = 0; i < 8; i++) begin
               for (int j = 0; j < 8; j++) begin
                  wr(3'd1, vals[i]);
                  wr(3'd2, vals[j]);
                  settle();
                  r = model(m_acc, vals[i], vals[j], s[0], 2'(op));
                  m_acc = r[47:0];
                  m_ovf = m_ovf | r[48];
                  rd_acc(acc);
                  check(tag, 64'(acc), 64'(m_acc));
                  rd(3'd0, d);
                  check("R9 overflow in sweep", 64'(d[6]), 64'(m_ovf));
               end
            end
         end
      end

      // R5: one-cycle latency
      wr(3'd0, 16'h0080);
      wr(3'd1, 16'd3);
      wr(3'd2, 16'd5);
      rd(3'd3, d);
      check("R5 before update", 64'(d), 64'd0);
      settle();
      rd(3'd3, d);
      check("R5 after update", 64'(d), 64'd15);

      // R6: back-to-back triggers, single-operand accumulate
      wr(3'd0, 16'h0080 | 16'h0008 | 16'h0002);
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd1);
      wr(3'd2, 16'd2);
      wr(3'd2, 16'd3);
      settle();
      rd_acc(acc);
      check("R6 back-to-back", 64'(acc), 64'd12);

      // R7: two-operand arming
      wr(3'd0, 16'h0080 | 16'h0002);
      wr(3'd1, 16'd4);
      wr(3'd2, 16'd5);
      settle();
      rd_acc(acc);
      check("R7 armed pair", 64'(acc), 64'd20);
      wr(3'd2, 16'd6);
      settle(); settle();
      rd_acc(acc);
      check("R7 unarmed B ignored", 64'(acc), 64'd20);
      wr(3'd1, 16'd1);
      wr(3'd2, 16'd7);
      settle();
      rd_acc(acc);
      check("R7 rearmed pair", 64'(acc), 64'd27);

      // R8: square
      wr(3'd0, 16'h0080 | 16'h0010 | 16'h0001);
      wr(3'd1, 16'hFFFD);
      settle();
      rd_acc(acc);
      check("R8 square result", 64'(acc), 64'd9);
      wr(3'd2, 16'd100);
      settle(); settle();
      rd_acc(acc);
      check("R8 B write no start", 64'(acc), 64'd9);
      rd(3'd2, d);
      check("R8 B stored", 64'(d), 64'd100);

      // R9: unsigned carry out, then stickiness
      wr(3'd0, 16'h0080 | 16'h0002);
      wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF);
      wr(3'd1, 16'd1);
      wr(3'd2, 16'd1);
      settle();
      rd_acc(acc);
      check("R9 carry wrap", 64'(acc), 64'd0);
      rd(3'd0, d);
      check("R9 carry flag", 64'(d[6]), 64'd1);
      wr(3'd0, 16'h0000);
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd2);
      settle();
      rd(3'd0, d);
      check("R9 sticky after multiply", 64'(d[7:0]), 64'h40);

      // R9: signed subtract overflow
      wr(3'd0, 16'h0080 | 16'h0004 | 16'h0001);
      wr(3'd5, 16'h8000);
      wr(3'd1, 16'd1);
      wr(3'd2, 16'd1);
      settle();
      rd_acc(acc);
      check("R9 signed wrap", 64'(acc), 64'h7FFF_FFFF_FFFF);
      rd(3'd0, d);
      check("R9 signed flag", 64'(d[6]), 64'd1);

      // R10: clear
      wr(3'd0, 16'h0081);
      rd(3'd0, d);
      check("R10 ctrl after clear", 64'(d), 64'h01);
      rd_acc(acc);
      check("R10 acc cleared", 64'(acc), 64'd0);
      rd(3'd1, d);
      check("R10 A cleared", 64'(d), 64'd0);
      rd(3'd2, d);
      check("R10 B cleared", 64'(d), 64'd0);

      // R11: lock and direct word writes
      wr(3'd0, 16'h0020);
      wr(3'd4, 16'h1234);
      rd_acc(acc);
      check("R11 locked write ignored", 64'(acc), 64'd0);
      wr(3'd0, 16'h0000);
      wr(3'd4, 16'h1234);
      rd_acc(acc);
      check("R11 word write", 64'(acc), 64'h0000_1234_0000);
      rd(3'd6, d);
      check("R1 unmapped read", 64'(d), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule